// File: doc/BRIEF.md
# DDR2 Clock-Enable Power-Mode Sequencer

This block sits on the controller side of a DDR2 interface. It owns the clock-enable pin and the four command strobes whenever the memory goes into or comes out of a low-power mode. A scheduler holds a power-down request or a self-refresh request as a level. Status inputs say whether any bank is open, whether an operation is still in flight, whether driver calibration is running and whether a refresh is due. The sequencer picks the legal moment to drop the clock enable and chooses the kind of low-power mode from the bank state. It keeps the clock enable at each level for a minimum number of clocks. After leaving a mode it reports when general commands, and separately reads, may resume.

The controller has six states. `ST_RUN` is the normal operating state, with the clock enable high. `ST_APD` is power-down with at least one bank open, and `ST_PPD` is power-down with all banks closed. `ST_SRE` is the single clock in which self-refresh is entered. `ST_SRF` is held for the rest of self-refresh. `ST_WAKE` is the single clock in which the clock enable rises again.

The transitions are:
- power-down entry: `ST_RUN` to `ST_APD` or `ST_PPD`.
- self-refresh entry: `ST_RUN` to `ST_SRE`, then `ST_SRE` to `ST_SRF` on the next clock.
- power-down exit: `ST_APD` or `ST_PPD` to `ST_WAKE`.
- self-refresh exit: `ST_SRF` to `ST_WAKE`.
- resume: `ST_WAKE` to `ST_RUN`.

A request that cannot be served yet stays pending for as long as the scheduler keeps it raised.

Top module: `cke_lpm_sequencer`

## Requirements
- R1: After reset the outputs are as follows: clock enable high; command bus DESELECT (cs_n, ras_n, cas_n and we_n all 1); lp_mode 0; ready_cmd and ready_read high; sr_bank_err low.
- R2: Power-down entry happens when all of these hold in the normal state: pd_req is high, nothing blocks entry, and the clock enable has been high for at least CKE_MIN clocks. In the next cycle the clock enable is low and the bus carries NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1). lp_mode is then 1 if bank_open was high at the deciding edge, and 2 if it was low.
- R3: Self-refresh entry happens when sr_req is high, bank_open is low and nothing blocks entry. The clock enable falls in the same cycle that the bus carries AUTOREFRESH (0,0,0,1), and lp_mode becomes 3. NOP follows for the rest of self-refresh. A self-refresh request wins over a power-down request.
- R4: op_busy, calib_active and refresh_due each block entry into either mode. A blocked request stays pending, and the mode is entered on the first edge at which the block is gone.
- R5: sr_bank_err is high in the normal state while sr_req and bank_open are both high. Self-refresh is then not entered, and the request waits until the banks close.
- R6: Once the clock enable changes level, it keeps that level for at least CKE_MIN (default 3) cycles, whether high or low.
- R7: Power-down ends when pd_req falls, refresh_due rises or calib_active rises. Self-refresh ends when sr_req falls or calib_active rises. Either exit waits until the minimum low time is met. In the exit cycle the clock enable is high, the bus carries NOP, lp_mode is 0 and ready_cmd is low.
- R8: After a power-down exit, ready_cmd and ready_read are both high in the cycle after the exit cycle.
- R9: After a self-refresh exit, the bus carries NOP and ready_cmd stays low for XSNR_CYC cycles, counting the exit cycle as the first. ready_cmd rises exactly XSNR_CYC cycles after the exit cycle. No low-power entry is made during that window.
- R10: After a self-refresh exit, ready_read rises exactly XSRD_CYC (default 200) cycles after the exit cycle. This count is independent of XSNR_CYC. ready_read is never high while ready_cmd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Power-down request level from the scheduler |
| sr_req | input | 1 | Self-refresh request level from the scheduler |
| bank_open | input | 1 | At least one bank is open |
| op_busy | input | 1 | Read, write, mode-register, precharge or refresh operation in progress |
| calib_active | input | 1 | Driver calibration mode is active |
| refresh_due | input | 1 | A refresh must be issued soon |
| cke | output | 1 | DDR2 clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| lp_mode | output | 2 | 0 normal, 1 active power-down, 2 precharge power-down, 3 self-refresh |
| ready_cmd | output | 1 | General commands may be issued |
| ready_read | output | 1 | Reads may be issued |
| sr_bank_err | output | 1 | Self-refresh requested while a bank is open |

## Verification
The bench probes several corner cases.

- It drops a request on the very cycle the clock enable falls. A design that tracked only the request would pulse the clock enable low for a single clock.
- It raises a new request right after a wake-up. A design without the high-time counter would re-enter within three clocks.
- It keeps the exit counters separate by shortening the general-command window to 12 clocks while reads stay at 200. A shared counter would release both flags together.
- Around self-refresh, it checks that AUTOREFRESH appears only on the falling edge of the clock enable and never with a bank open.
- It forces exits with refresh_due and calib_active, and shows that a blocked request is entered later rather than lost.

// File: rtl/cke_lpm_pkg.sv
package cke_lpm_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_APD  = 3'd1,
        ST_PPD  = 3'd2,
        ST_SRE  = 3'd3,
        ST_SRF  = 3'd4,
        ST_WAKE = 3'd5
    } lpm_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ddr_cmd_t;

    localparam ddr_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam ddr_cmd_t CMD_DES  = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam ddr_cmd_t CMD_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    localparam logic [1:0] MODE_NORMAL = 2'd0;
    localparam logic [1:0] MODE_APD    = 2'd1;
    localparam logic [1:0] MODE_PPD    = 2'd2;
    localparam logic [1:0] MODE_SREF   = 2'd3;

    function automatic logic state_cke(input lpm_state_e s);
        return !(s == ST_APD || s == ST_PPD || s == ST_SRE || s == ST_SRF);
    endfunction
endpackage

// File: rtl/cke_hold_timer.sv
module cke_hold_timer #(
    parameter int CKE_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke_next,
    output logic cke,
    output logic hold_met
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = $clog2(CKE_MIN + 1);
    localparam logic [AW-1:0] AGE_MAX = AW'(CKE_MIN);
    localparam logic [AW-1:0] AGE_ONE = AW'(1);

    logic [AW-1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke <= 1'b1;
            age <= AGE_MAX;
        end else begin
            cke <= cke_next;
            if (cke_next != cke) begin
                age <= AGE_ONE;
            end else if (age != AGE_MAX) begin
                age <= age + AGE_ONE;
            end
        end
    end

    assign hold_met = (age == AGE_MAX);

    // R6: a level change is requested only once the current level has aged out
    assert_toggle_after_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_next != cke) |-> hold_met);
endmodule

// File: rtl/lpm_window_counter.sv
module lpm_window_counter #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign busy = (cnt != '0);

    // R9: a load always opens a window on the following cycle
    assert_load_opens_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
endmodule

// File: rtl/cke_lpm_fsm.sv
module cke_lpm_fsm
    import cke_lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       sr_req,
    input  logic       bank_open,
    input  logic       op_busy,
    input  logic       calib_active,
    input  logic       refresh_due,
    input  logic       hold_met,
    input  logic       xsnr_busy,
    input  logic       xsrd_busy,
    output logic       cke_next,
    output ddr_cmd_t   cmd,
    output logic [1:0] lp_mode,
    output logic       sr_exit_load,
    output logic       ready_cmd,
    output logic       ready_read,
    output logic       sr_bank_err
);
    timeunit 1ns;
    timeprecision 1ps;

    lpm_state_e state;
    lpm_state_e state_nxt;
    logic       entry_blocked;
    logic       pd_leave;
    logic       sr_leave;

    assign entry_blocked = op_busy | calib_active | refresh_due | !hold_met | xsnr_busy;
    assign pd_leave      = hold_met & (!pd_req | refresh_due | calib_active);
    assign sr_leave      = hold_met & (!sr_req | calib_active);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (!entry_blocked && sr_req && !bank_open) begin
                    state_nxt = ST_SRE;
                end else if (!entry_blocked && pd_req) begin
                    state_nxt = bank_open ? ST_APD : ST_PPD;
                end
            end
            ST_APD, ST_PPD: begin
                if (pd_leave) begin
                    state_nxt = ST_WAKE;
                end
            end
            ST_SRE: begin
                state_nxt = ST_SRF;
            end
            ST_SRF: begin
                if (sr_leave) begin
                    state_nxt = ST_WAKE;
                end
            end
            ST_WAKE: begin
                state_nxt = ST_RUN;
            end
            default: begin
                state_nxt = ST_RUN;
            end
        endcase
    end

    assign cke_next     = state_cke(state_nxt);
    assign sr_exit_load = (state == ST_SRF) && (state_nxt == ST_WAKE);

    always_comb begin
        cmd         = CMD_NOP;
        lp_mode     = MODE_NORMAL;
        ready_cmd   = 1'b0;
        sr_bank_err = 1'b0;
        unique case (state)
            ST_RUN: begin
                cmd         = xsnr_busy ? CMD_NOP : CMD_DES;
                ready_cmd   = !xsnr_busy;
                sr_bank_err = sr_req && bank_open;
            end
            ST_APD:  lp_mode = MODE_APD;
            ST_PPD:  lp_mode = MODE_PPD;
            ST_SRE: begin
                cmd     = CMD_AREF;
                lp_mode = MODE_SREF;
            end
            ST_SRF:  lp_mode = MODE_SREF;
            ST_WAKE: lp_mode = MODE_NORMAL;
            default: lp_mode = MODE_NORMAL;
        endcase
    end

    assign ready_read = ready_cmd && !xsrd_busy;

    // R3: the self-refresh entry state is reached only with every bank closed
    assert_sre_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SRE) |-> $past(!bank_open && sr_req));

    // R7: the wake cycle is always followed by normal operation
    assert_wake_to_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |=> (state == ST_RUN));
endmodule

// File: rtl/cke_lpm_sequencer.sv
module cke_lpm_sequencer
    import cke_lpm_pkg::*;
#(
    parameter int CKE_MIN  = 3,
    parameter int XSNR_CYC = 200,
    parameter int XSRD_CYC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       sr_req,
    input  logic       bank_open,
    input  logic       op_busy,
    input  logic       calib_active,
    input  logic       refresh_due,
    output logic       cke,
    output logic       cs_n,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic [1:0] lp_mode,
    output logic       ready_cmd,
    output logic       ready_read,
    output logic       sr_bank_err
);
    timeunit 1ns;
    timeprecision 1ps;

    logic     cke_next;
    logic     hold_met;
    logic     sr_exit_load;
    logic     xsnr_busy;
    logic     xsrd_busy;
    ddr_cmd_t cmd;

    cke_lpm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pd_req       (pd_req),
        .sr_req       (sr_req),
        .bank_open    (bank_open),
        .op_busy      (op_busy),
        .calib_active (calib_active),
        .refresh_due  (refresh_due),
        .hold_met     (hold_met),
        .xsnr_busy    (xsnr_busy),
        .xsrd_busy    (xsrd_busy),
        .cke_next     (cke_next),
        .cmd          (cmd),
        .lp_mode      (lp_mode),
        .sr_exit_load (sr_exit_load),
        .ready_cmd    (ready_cmd),
        .ready_read   (ready_read),
        .sr_bank_err  (sr_bank_err)
    );

    cke_hold_timer #(.CKE_MIN(CKE_MIN)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke_next (cke_next),
        .cke      (cke),
        .hold_met (hold_met)
    );

    lpm_window_counter #(.CYCLES(XSNR_CYC)) u_xsnr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sr_exit_load),
        .busy  (xsnr_busy)
    );

    lpm_window_counter #(.CYCLES(XSRD_CYC)) u_xsrd (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sr_exit_load),
        .busy  (xsrd_busy)
    );

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;

    // R3: AUTOREFRESH appears only on the cycle the clock enable falls, banks idle
    assert_aref_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_AREF) |-> ($fell(cke) && $past(!bank_open)));

    // R4: no low-power entry while a blocking condition was present
    assert_no_entry_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(!op_busy && !calib_active && !refresh_due));

    // R2: every clock-enable edge carries NOP or AUTOREFRESH, never a real command
    assert_edge_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cke != $past(cke)) |-> (cmd == CMD_NOP || cmd == CMD_AREF));

    // R9: inside the post-exit window the bus is NOP and commands are held off
    assert_window_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xsnr_busy |-> (cmd == CMD_NOP && !ready_cmd));

    // R10: reads are never released ahead of general commands
    assert_read_needs_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_read |-> ready_cmd);

    // R5: a self-refresh request with an open bank never produces AUTOREFRESH next
    assert_err_blocks_sr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sr_bank_err |=> (cmd != CMD_AREF));
endmodule

// File: tb/tb_cke_lpm_sequencer.sv
module tb_cke_lpm_sequencer;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int XSNR = 12;
    localparam int XSRD = 200;
    localparam int HOLD = 3;

    localparam int M_RUN = 0, M_APD = 1, M_PPD = 2, M_SRE = 3, M_SRF = 4, M_WAKE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_req = 0, sr_req = 0, bank_open = 0, op_busy = 0, calib_active = 0, refresh_due = 0;
    logic cke, cs_n, ras_n, cas_n, we_n, ready_cmd, ready_read, sr_bank_err;
    logic [1:0] lp_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit cmp_on = 0;

    int m_st = M_RUN, m_age = HOLD, m_xs = 0, m_xr = 0;

    always #2 clk = ~clk;

    cke_lpm_sequencer #(.CKE_MIN(HOLD), .XSNR_CYC(XSNR), .XSRD_CYC(XSRD)) dut (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .sr_req(sr_req),
        .bank_open(bank_open), .op_busy(op_busy), .calib_active(calib_active),
        .refresh_due(refresh_due), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .lp_mode(lp_mode), .ready_cmd(ready_cmd),
        .ready_read(ready_read), .sr_bank_err(sr_bank_err)
    );

    function automatic logic f_cke(input int s);
        return !(s == M_APD || s == M_PPD || s == M_SRE || s == M_SRF);
    endfunction

    // bus encodings {cs_n,ras_n,cas_n,we_n}: NOP 0111, DESELECT 1111, AUTOREFRESH 0001
    function automatic logic [3:0] f_cmd(input int s, input int xs);
        if (s == M_RUN) return (xs != 0) ? 4'b0111 : 4'b1111;
        if (s == M_SRE) return 4'b0001;
        return 4'b0111;
    endfunction

    function automatic logic [1:0] f_mode(input int s);
        case (s)
            M_APD: return 2'd1;
            M_PPD: return 2'd2;
            M_SRE, M_SRF: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // reference model advanced from the requirements at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_RUN; m_age = HOLD; m_xs = 0; m_xr = 0;
        end else begin
            bit blk;
            int nx;
            blk = op_busy || calib_active || refresh_due || (m_age < HOLD) || (m_xs != 0);
            nx = m_st;
            case (m_st)
                M_RUN: begin
                    if (!blk && sr_req && !bank_open) nx = M_SRE;
                    else if (!blk && pd_req) nx = bank_open ? M_APD : M_PPD;
                end
                M_APD, M_PPD: if (m_age >= HOLD && (!pd_req || refresh_due || calib_active)) nx = M_WAKE;
                M_SRE: nx = M_SRF;
                M_SRF: if (m_age >= HOLD && (!sr_req || calib_active)) nx = M_WAKE;
                default: nx = M_RUN;
            endcase
            if (m_st == M_SRF && nx == M_WAKE) begin
                m_xs = XSNR; m_xr = XSRD;
            end else begin
                if (m_xs > 0) m_xs--;
                if (m_xr > 0) m_xr--;
            end
            if (f_cke(nx) != f_cke(m_st)) m_age = 1;
            else if (m_age < HOLD) m_age++;
            m_st = nx;
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            chk("R6 cke vs model", cke, f_cke(m_st));
            chk("R3 bus vs model", {cs_n, ras_n, cas_n, we_n}, f_cmd(m_st, m_xs));
            chk("R2 lp_mode vs model", lp_mode, f_mode(m_st));
            chk("R9 ready_cmd vs model", ready_cmd, (m_st == M_RUN) && (m_xs == 0));
            chk("R10 ready_read vs model", ready_read, (m_st == M_RUN) && (m_xs == 0) && (m_xr == 0));
            chk("R5 sr_bank_err vs model", sr_bank_err, (m_st == M_RUN) && sr_req && bank_open);
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        cyc(3);
        rst_n = 1'b1;
        cmp_on = 1;
        // R1 reset state
        chk("R1 cke", cke, 1);
        chk("R1 bus DESELECT", {cs_n, ras_n, cas_n, we_n}, 4'b1111);
        chk("R1 lp_mode", lp_mode, 0);
        chk("R1 ready_cmd", ready_cmd, 1);
        chk("R1 ready_read", ready_read, 1);
        chk("R1 sr_bank_err", sr_bank_err, 0);

        // precharge power-down, request dropped at once
        bank_open = 0; pd_req = 1;
        cyc(1);
        chk("R2 ppd cke", cke, 0);
        chk("R2 ppd bus NOP", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk("R2 ppd mode", lp_mode, 2);
        pd_req = 0;
        cyc(2);
        chk("R6 low hold", cke, 0);
        cyc(1);
        chk("R7 exit cke", cke, 1);
        chk("R7 exit bus NOP", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk("R7 exit mode", lp_mode, 0);
        chk("R7 exit ready_cmd", ready_cmd, 0);
        cyc(1);
        chk("R8 ready_cmd", ready_cmd, 1);
        chk("R8 ready_read", ready_read, 1);

        // active power-down requested before high time is met
        bank_open = 1; pd_req = 1;
        cyc(1);
        chk("R6 high hold", cke, 1);
        cyc(1);
        chk("R2 apd cke", cke, 0);
        chk("R2 apd mode", lp_mode, 1);

        // refresh_due forces exit and then blocks re-entry
        refresh_due = 1;
        cyc(2);
        chk("R6 low hold apd", cke, 0);
        cyc(1);
        chk("R7 refresh exit", cke, 1);
        cyc(5);
        chk("R4 refresh blocks", cke, 1);
        refresh_due = 0;
        cyc(1);
        chk("R4 pending entry", lp_mode, 1);
        pd_req = 0;
        cyc(4);

        // self-refresh requested with an open bank
        sr_req = 1;
        cyc(3);
        chk("R5 err flag", sr_bank_err, 1);
        chk("R5 no entry", cke, 1);
        bank_open = 0;
        cyc(1);
        chk("R3 sre cke", cke, 0);
        chk("R3 sre AUTOREFRESH", {cs_n, ras_n, cas_n, we_n}, 4'b0001);
        chk("R3 sre mode", lp_mode, 3);
        cyc(1);
        chk("R3 srf bus NOP", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        sr_req = 0;
        cyc(2);
        chk("R7 sr exit cke", cke, 1);
        chk("R7 sr exit ready_cmd", ready_cmd, 0);
        pd_req = 1;
        cyc(XSNR - 1);
        chk("R9 window ready_cmd", ready_cmd, 0);
        chk("R9 window NOP", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk("R9 no entry in window", cke, 1);
        cyc(1);
        pd_req = 0;
        chk("R9 ready_cmd rises", ready_cmd, 1);
        chk("R10 ready_read held", ready_read, 0);
        cyc(XSRD - XSNR - 1);
        chk("R10 ready_read before", ready_read, 0);
        cyc(1);
        chk("R10 ready_read rises", ready_read, 1);

        // op_busy and calibration
        op_busy = 1; pd_req = 1;
        cyc(3);
        chk("R4 op_busy blocks", cke, 1);
        op_busy = 0; calib_active = 1;
        cyc(3);
        chk("R4 calib blocks", cke, 1);
        calib_active = 0;
        cyc(1);
        chk("R4 entry after calib", lp_mode, 2);
        calib_active = 1;
        cyc(3);
        chk("R7 calib exit", cke, 1);
        calib_active = 0; pd_req = 0;
        cyc(4);

        // constrained random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            cyc(1);
            if (($urandom % 16) == 0) pd_req = ~pd_req;
            if (($urandom % 24) == 0) sr_req = ~sr_req;
            if (($urandom % 10) == 0) bank_open = ~bank_open;
            op_busy = (($urandom % 6) == 0);
            if (($urandom % 30) == 0) refresh_due = ~refresh_due;
            if (calib_active) calib_active = (($urandom % 4) != 0);
            else calib_active = (($urandom % 90) == 0);
        end
        cyc(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule